// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a synchronous serial slave that gives a host controller read and write access to a bank of 8-bit configuration registers. The host frames each transaction with an active-low chip select and picks its direction with a read/write select. It then clocks sixteen bits over a single data line: an address byte first, then a data byte. The data line is a bidirectional pad, brought out here as an input, an output and an output enable.

On a write, the block updates the addressed register. On a read, it shifts that register's contents back out. The register at index 0 is a fixed identification byte. A range of radio-control registers is protected: those registers can only be written while both the transmit and the receive power enables are low. A write to them at any other time is dropped and raises a sticky error flag.

The serial inputs are sampled in the system clock domain. All serial activity is keyed to rising edges of the serial clock.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset, `sd_oe` and `wr_err` are 0. Every register n from 1 to NREG-1 holds the value n XOR 8'h5A.
- R2: Register 0 always reads {PART_CODE, VERSION_CODE}, which is 8'h32 by default. Writes to register 0 have no effect.
- R3: A transaction has 16 rising serial-clock edges. The first 8 carry the address and the last 8 carry the data, each most significant bit first. The read/write select is captured on the first edge, with 1 meaning read and 0 meaning write.
- R4: The register index is bits 7:2 of the address byte. Bits 1:0 are ignored, so register n sits at address 4*n.
- R5: A completed write updates the addressed register. A later read of it returns the written byte.
- R6: Registers LOCK_FIRST to LOCK_LAST (1 to 3 by default) keep their value when a write arrives while `tx_pe` or `rx_pe` is high. Other registers stay writable in that state.
- R7: A dropped write to a locked register sets `wr_err`. Once set, `wr_err` stays high until reset.
- R8: If chip select rises before the 16th edge, the transaction is aborted and no register changes. The next transaction starts from bit 0.
- R9: On a read, the block launches the data MSB on the 8th rising edge. It shifts one bit per following edge and drives `sd_oe` only until the 16th edge. `sd_oe` is low during the address phase and during writes.
- R10: Indices NREG and above read as 8'h00, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, sampled by clk |
| cs_n | input | 1 | Active-low chip select framing a transaction |
| rw | input | 1 | Direction select: 1 read, 0 write |
| sd_i | input | 1 | Serial data from the pad |
| sd_o | output | 1 | Serial data to the pad |
| sd_oe | output | 1 | Pad drive enable for sd_o |
| tx_pe | input | 1 | Transmit path enable |
| rx_pe | input | 1 | Receive path enable |
| wr_err | output | 1 | Sticky flag for a dropped locked write |

## Verification
The hardest case to produce from the ports is an aborted frame. Chip select has to rise after some address and data bits have been taken in, but before the 16th edge. The following transaction must then realign from bit 0 rather than continue the partial count. The stimulus runs a 12-edge write to a register whose value is already known, releases chip select, and then performs a full read of the same register. The read must return the old value, which also shows that the bit counter restarted. The lock path needs each power enable raised on its own around full writes, with readback afterwards to show the registers stayed unchanged.

// File: rtl/cfg_serial_port.sv
module cfg_serial_port #(
  parameter int NREG         = 16,
  parameter int LOCK_FIRST   = 1,
  parameter int LOCK_LAST    = 3,
  parameter logic [3:0] PART_CODE    = 4'h3,
  parameter logic [3:0] VERSION_CODE = 4'h2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic rw,
  input  logic sd_i,
  output logic sd_o,
  output logic sd_oe,
  input  logic tx_pe,
  input  logic rx_pe,
  output logic wr_err
);
  localparam int IW = 6;

  logic        sclk_q;
  logic [3:0]  cnt;
  logic [14:0] sh_in;
  logic        rw_q;
  logic [7:0]  out_sr;
  logic        oe_q;
  logic [7:0]  regs [NREG];

  wire         rise     = sclk & ~sclk_q & ~cs_n;
  wire [7:0]   addr_now = {sh_in[6:0], sd_i};
  wire [IW-1:0] rd_idx  = addr_now[7:2];
  wire [IW-1:0] wr_idx  = sh_in[14:9];
  wire [7:0]   wr_data  = {sh_in[6:0], sd_i};
  wire         commit   = rise && cnt == 4'd15 && !rw_q;
  wire         busy     = tx_pe | rx_pe;
  wire         wr_lock  = int'(wr_idx) >= LOCK_FIRST && int'(wr_idx) <= LOCK_LAST;
  wire         wr_ok    = wr_idx != '0 && int'(wr_idx) < NREG && !(wr_lock && busy);

  function automatic logic [7:0] rd_val(input logic [IW-1:0] idx);
    if (idx == '0) return {PART_CODE, VERSION_CODE};
    for (int n = 1; n < NREG; n++)
      if (int'(idx) == n) return regs[n];
    return 8'h00;
  endfunction

  assign sd_o  = out_sr[7];
  assign sd_oe = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cnt    <= '0;
      sh_in  <= '0;
      rw_q   <= 1'b0;
      out_sr <= '0;
      oe_q   <= 1'b0;
    end else begin
      sclk_q <= sclk;
      if (cs_n) begin
        cnt  <= '0;
        oe_q <= 1'b0;
      end else if (rise) begin
        sh_in <= {sh_in[13:0], sd_i};
        cnt   <= cnt + 4'd1;
        if (cnt == 4'd0) rw_q <= rw;
        if (cnt == 4'd7 && rw_q) begin
          out_sr <= rd_val(rd_idx);
          oe_q   <= 1'b1;
        end else if (oe_q) begin
          out_sr <= {out_sr[6:0], 1'b0};
        end
        if (cnt == 4'd15) oe_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_err <= 1'b0;
      for (int n = 0; n < NREG; n++) regs[n] <= 8'(n) ^ 8'h5A;
    end else if (commit) begin
      if (wr_ok) regs[wr_idx[$clog2(NREG)-1:0]] <= wr_data;
      if (wr_lock && busy) wr_err <= 1'b1;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) !$fell(wr_err)) else $error("wr_err cleared"); // R7
  AST_LOCK_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(regs[LOCK_FIRST])) else $error("locked reg changed"); // R6
  AST_OE_READ:    assert property (@(posedge clk) disable iff (!rst_n) sd_oe |-> rw_q) else $error("drive on write"); // R9
  AST_CS_IDLE:    assert property (@(posedge clk) disable iff (!rst_n) cs_n |=> (!sd_oe && cnt == 4'd0)) else $error("abort not clean"); // R8
  AST_SDO_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) !rise |=> $stable(sd_o)) else $error("sd_o moved off edge"); // R3
endmodule

// File: tb/sim_cfg_serial_port.sv
module sim_cfg_serial_port;
  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, rw = 0, sd_i = 0, tx_pe = 0, rx_pe = 0;
  logic sd_o, sd_oe, wr_err;
  int checks = 0, failures = 0;
  logic oe_addr, oe_data;

  always #5 clk = ~clk;

  cfg_serial_port u0 (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .rw(rw), .sd_i(sd_i),
    .sd_o(sd_o), .sd_oe(sd_oe), .tx_pe(tx_pe), .rx_pe(rx_pe), .wr_err(wr_err));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic dir, input logic [7:0] addr, input logic [7:0] wd,
                      input int nbits, output logic [7:0] rd);
    logic [15:0] frame = {addr, wd};
    rd = '0;
    @(negedge clk); cs_n = 0; rw = dir;
    for (int i = 0; i < nbits; i++) begin
      sd_i = frame[15-i];
      repeat (2) @(negedge clk);
      if (i == 3) oe_addr = sd_oe;
      if (i == 10) oe_data = sd_oe;
      if (i >= 8) rd = {rd[6:0], sd_o};
      sclk = 1;
      repeat (2) @(negedge clk);
      sclk = 0;
    end
    repeat (2) @(negedge clk);
    cs_n = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] addr, input logic [7:0] exp);
    logic [7:0] v;
    xfer(1, addr, 8'h00, 16, v);
    chk(req, v, exp);
  endtask

  task automatic wr(input logic [7:0] addr, input logic [7:0] d);
    logic [7:0] v;
    xfer(0, addr, d, 16, v);
  endtask

  task automatic t_reset;
    chk("R1 sd_oe", {7'd0, sd_oe}, 8'h00);
    chk("R1 wr_err", {7'd0, wr_err}, 8'h00);
    rd_chk("R1 default reg5", 8'h14, 8'h5F);
  endtask

  task automatic t_id;
    rd_chk("R2 id", 8'h00, 8'h32);
    wr(8'h00, 8'hFF);
    rd_chk("R2 id after write", 8'h00, 8'h32);
  endtask

  task automatic t_write;
    wr(8'h14, 8'hC3);
    rd_chk("R5 R3 reg5 readback", 8'h14, 8'hC3);
    wr(8'h1B, 8'h77);
    rd_chk("R4 low bits ignored", 8'h18, 8'h77);
  endtask

  task automatic t_oe;
    logic [7:0] v;
    xfer(1, 8'h18, 8'h00, 16, v);
    chk("R9 oe in address phase", {7'd0, oe_addr}, 8'h00);
    chk("R9 oe in data phase", {7'd0, oe_data}, 8'h01);
    chk("R9 oe after read", {7'd0, sd_oe}, 8'h00);
    xfer(0, 8'h24, 8'h11, 16, v);
    chk("R9 oe on write", {7'd0, oe_data}, 8'h00);
  endtask

  task automatic t_lock;
    tx_pe = 1;
    wr(8'h08, 8'h99);
    rd_chk("R6 reg2 locked by tx", 8'h08, 8'h58);
    chk("R7 err set", {7'd0, wr_err}, 8'h01);
    wr(8'h1C, 8'hAB);
    rd_chk("R6 reg7 writable while busy", 8'h1C, 8'hAB);
    tx_pe = 0; rx_pe = 1;
    wr(8'h0C, 8'h44);
    rd_chk("R6 reg3 locked by rx", 8'h0C, 8'h59);
    rx_pe = 0;
    wr(8'h08, 8'h99);
    rd_chk("R6 reg2 after release", 8'h08, 8'h99);
    chk("R7 err sticky", {7'd0, wr_err}, 8'h01);
  endtask

  task automatic t_abort;
    logic [7:0] v;
    xfer(0, 8'h14, 8'h3C, 12, v);
    rd_chk("R8 abort keeps reg5", 8'h14, 8'hC3);
  endtask

  task automatic t_range;
    wr(8'h40, 8'h12);
    rd_chk("R10 out of range", 8'h40, 8'h00);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        t_reset; t_id; t_write; t_oe; t_lock; t_abort; t_range;
      end
      begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule